// File: doc/BRIEF.md
# PRBS Sync Detector with Bit-Error Counter

This block compares an unframed received bit stream with a pseudo-random test sequence and counts the bits that disagree. Each received bit can first pass through an optional inverter. The block holds a local history of past bits and uses it to predict the next bit. While the block is hunting, the history is filled from the incoming bits themselves. Once enough consecutive predictions come true, the block declares pattern sync. From then on the history runs on its own predictions, so a single corrupted line bit counts as exactly one error.

A host selects the polynomial, sets the enable bit, can issue a one-cycle reseed command, and reads the 16-bit error count. Reading the count clears it. Errors are counted only while the block is enabled and in sync. At any other time the count holds its value until it is read. A burst of errors drops sync, and the block then hunts again by itself. Note that with inversion selected, a steady all-ones input looks like a valid all-zero pattern and produces sync.

Top module: `prbs_err_monitor`

## Requirements
- R1: After reset, `sync_o` is 0 and `err_cnt` is 0.
- R2: With `poly_sel`=0, each predicted bit is the XOR of the bits received 15 and 14 positions earlier (x^15+x^14+1). With `poly_sel`=1, it is the XOR of the bits 20 and 17 positions earlier (x^20+x^17+1). A clean stream of the selected pattern reaches sync within 100 bits. A stream of the other pattern never reaches sync.
- R3: A reseed clears the history to zero. `sync_o` rises at the clock edge that samples the 32nd consecutive valid bit matching the prediction, and not earlier.
- R4: While enabled and in sync, each valid bit that differs from the prediction adds one to `err_cnt`. After sync, prediction no longer uses received bits.
- R5: Sync is dropped when 6 errors fall within one 64-bit window that starts at sync. Six errors spread 20 bits apart keep sync.
- R6: After losing sync, the block hunts again from the incoming bits with no host action, and regains sync on a clean stream. Mismatches seen while hunting are not counted.
- R7: `invert`=1 complements each received bit before comparison. An inverted pattern then reaches sync, and a steady all-ones input also reaches sync.
- R8: A reseed with `det_en`=1 forces `sync_o` to 0 at the next edge and restarts the hunt. The command lasts one cycle only.
- R9: With `det_en`=0, `sync_o` reads 0, valid bits are ignored, `err_cnt` holds its value, and a reseed has no effect. The sync state held before disabling returns when `det_en` goes back to 1.
- R10: `cnt_rd`=1 clears `err_cnt` at the next edge. If an error is counted in the same cycle, the result is 1.
- R11: `err_cnt` saturates at all ones (parameter `CNT_W`).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_in | input | 1 | Received serial data bit |
| bit_vld | input | 1 | Qualifies `bit_in` for this cycle |
| det_en | input | 1 | Detector and counter enable |
| reseed | input | 1 | One-cycle command to restart the hunt |
| poly_sel | input | 1 | 0: 2^15-1 pattern, 1: 2^20-1 pattern |
| invert | input | 1 | Complement received bits before checking |
| cnt_rd | input | 1 | Host read strobe; clears the counter |
| sync_o | output | 1 | Pattern sync flag |
| err_cnt | output | CNT_W (16) | Saturating bit-error count |

## Verification
Every registered result is due one clock edge after the input that causes it. This covers a sync change, a count step, a read clear, and the effect of a reseed. The one exception is `sync_o` falling on a low `det_en`, which happens within the same cycle. The bench therefore changes inputs on the falling edge and reads results on the next falling edge. The only exception is the disable check, which is read shortly after `det_en` drops. The R3 check counts bits one by one to confirm that sync rises on the 32nd matching bit and not on the 31st.

// File: rtl/prbs_mon_pkg.sv
// Shared constants and types for the PRBS sync detector.
// Assumes at most two selectable polynomials; tap positions are 1-based delays.
package prbs_mon_pkg;

    localparam int HIST_W = 20;
    localparam int NPOLY  = 2;

    typedef enum logic {
        ST_HUNT = 1'b0,
        ST_LOCK = 1'b1
    } det_state_t;

    // Longer feedback delay for polynomial index p
    function automatic int tap_far(input int p);
        return (p == 0) ? 15 : 20;
    endfunction

    // Shorter feedback delay for polynomial index p
    function automatic int tap_near(input int p);
        return (p == 0) ? 14 : 17;
    endfunction

endpackage

// File: rtl/prbs_predictor.sv
// Bit history and next-bit predictor.
// While hunting, it shifts in received bits (self-seeding). Once locked,
// it shifts in its own prediction. Assumes HIST_W covers the longest tap.
module prbs_predictor
    import prbs_mon_pkg::*;
#(
    parameter int HW = HIST_W
) (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    input  logic clr,
    input  logic poly_sel,
    input  logic self_run,
    input  logic d_in,
    output logic pred
);

    logic [HW-1:0]    hist;
    logic [NPOLY-1:0] fb;

    // One feedback XOR per selectable polynomial
    for (genvar p = 0; p < NPOLY; p++) begin : g_tap
        assign fb[p] = hist[tap_far(p)-1] ^ hist[tap_near(p)-1];
    end

    assign pred = fb[poly_sel];

    // Shift history: clear on reset/reseed, else advance on each accepted bit
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            hist <= '0;
        end else if (adv) begin
            hist <= {hist[HW-2:0], self_run ? pred : d_in};
        end
    end

endmodule

// File: rtl/prbs_sync_ctrl.sv
// Hunt/lock controller. Declares lock after MATCH_N consecutive matches and
// drops lock when LOSS_N errors land inside one WIN_N-bit window.
// Holds all state while disabled; reseed acts only while enabled.
module prbs_sync_ctrl
    import prbs_mon_pkg::*;
#(
    parameter int MATCH_N = 32,
    parameter int WIN_N   = 64,
    parameter int LOSS_N  = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic reseed,
    input  logic vld,
    input  logic mism,
    output logic locked
);

    localparam int MW = $clog2(MATCH_N);
    localparam int WW = $clog2(WIN_N);
    localparam int EW = $clog2(LOSS_N + 1);

    det_state_t       st;
    logic [MW-1:0]    match_cnt;
    logic [WW-1:0]    win_pos;
    logic [EW-1:0]    win_err;
    logic [EW-1:0]    err_next;

    assign err_next = win_err + EW'(mism);
    assign locked   = (st == ST_LOCK);

    // State, match run length and error window bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_HUNT;
            match_cnt <= '0;
            win_pos   <= '0;
            win_err   <= '0;
        end else if (en && reseed) begin
            st        <= ST_HUNT;
            match_cnt <= '0;
        end else if (en && vld) begin
            if (st == ST_HUNT) begin
                if (mism) begin
                    match_cnt <= '0;
                end else if (match_cnt == MW'(MATCH_N - 1)) begin
                    st        <= ST_LOCK;
                    match_cnt <= '0;
                    win_pos   <= '0;
                    win_err   <= '0;
                end else begin
                    match_cnt <= match_cnt + 1'b1;
                end
            end else begin
                if (err_next >= EW'(LOSS_N)) begin
                    st        <= ST_HUNT;
                    match_cnt <= '0;
                end else if (win_pos == WW'(WIN_N - 1)) begin
                    win_pos <= '0;
                    win_err <= '0;
                end else begin
                    win_pos <= win_pos + 1'b1;
                    win_err <= err_next;
                end
            end
        end
    end

    // R8
    reseed_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && reseed) |=> !locked);

    // R9
    disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(locked));

    // R3
    lock_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> ($past(match_cnt) == MW'(MATCH_N - 1)));

    // R5
    window_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> (win_err < EW'(LOSS_N)));

endmodule

// File: rtl/prbs_err_counter.sv
// Saturating error counter. A host read clears it; an error counted in the
// same cycle as the read leaves a count of one.
module prbs_err_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         rd,
    output logic [W-1:0] cnt
);

    // Clear-on-read with saturating increment
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (rd) begin
            cnt <= inc ? W'(1) : '0;
        end else if (inc && (cnt != '1)) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R10
    rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> (cnt <= W'(1)));

    // R11
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt == '1) && !rd) |=> (cnt == '1));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd && !inc) |=> $stable(cnt));

endmodule

// File: rtl/prbs_err_monitor.sv
// Top level of the PRBS sync detector. Optionally inverts the received bit,
// predicts the pattern, runs the hunt/lock controller and counts errors while
// enabled and locked. Assumes bit_in is meaningful only when bit_vld is 1.
module prbs_err_monitor
    import prbs_mon_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int MATCH_N = 32,
    parameter int WIN_N   = 64,
    parameter int LOSS_N  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_in,
    input  logic             bit_vld,
    input  logic             det_en,
    input  logic             reseed,
    input  logic             poly_sel,
    input  logic             invert,
    input  logic             cnt_rd,
    output logic             sync_o,
    output logic [CNT_W-1:0] err_cnt
);

    logic d_eff;
    logic pred;
    logic mism;
    logic locked;
    logic accept;
    logic count_err;

    assign d_eff     = bit_in ^ invert;
    assign mism      = d_eff ^ pred;
    assign accept    = det_en && bit_vld && !reseed;
    assign count_err = det_en && bit_vld && locked && mism;
    assign sync_o    = det_en && locked;

    prbs_predictor #(.HW(HIST_W)) u_pred (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv      (accept),
        .clr      (det_en && reseed),
        .poly_sel (poly_sel),
        .self_run (locked),
        .d_in     (d_eff),
        .pred     (pred)
    );

    prbs_sync_ctrl #(
        .MATCH_N (MATCH_N),
        .WIN_N   (WIN_N),
        .LOSS_N  (LOSS_N)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (det_en),
        .reseed (reseed),
        .vld    (bit_vld),
        .mism   (mism),
        .locked (locked)
    );

    prbs_err_counter #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (count_err),
        .rd    (cnt_rd),
        .cnt   (err_cnt)
    );

    // R4
    count_needs_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(err_cnt) && !$past(cnt_rd)) |-> $past(sync_o && bit_vld));

endmodule

// File: tb/prbs_err_monitor_bench.sv
// Self-checking bench: a table of pattern runs, then directed corner tests.
module prbs_err_monitor_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_in = 1'b0;
    logic        bit_vld = 1'b0;
    logic        det_en = 1'b0;
    logic        reseed = 1'b0;
    logic        poly_sel = 1'b0;
    logic        invert = 1'b0;
    logic        cnt_rd = 1'b0;
    logic        sync_o;
    logic        sync_n;
    logic [15:0] err_cnt;
    logic [3:0]  err_cnt_n;

    int n_chk = 0;
    int n_bad = 0;
    logic [19:0] gen;
    localparam logic [19:0] SEED = 20'hFFFFF;

    always #10 clk = ~clk;

    prbs_err_monitor u_prbs_err_monitor (
        .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_vld(bit_vld),
        .det_en(det_en), .reseed(reseed), .poly_sel(poly_sel), .invert(invert),
        .cnt_rd(cnt_rd), .sync_o(sync_o), .err_cnt(err_cnt)
    );

    prbs_err_monitor #(.CNT_W(4)) u_prbs_err_monitor_sat (
        .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_vld(bit_vld),
        .det_en(det_en), .reseed(reseed), .poly_sel(poly_sel), .invert(invert),
        .cnt_rd(cnt_rd), .sync_o(sync_n), .err_cnt(err_cnt_n)
    );

    typedef struct packed {
        logic       poly;
        logic       inv;
        logic [1:0] kind;   // 0 pattern, 1 all ones, 2 other pattern
        logic [7:0] nbits;
        logic [2:0] nerr;
        logic [4:0] gap;
        logic       xsync;
        logic [3:0] xcnt;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 1'b0, 2'd0, 8'd100, 3'd0, 5'd1,  1'b1, 4'd0},  // R2 R4
        '{1'b1, 1'b0, 2'd0, 8'd100, 3'd0, 5'd1,  1'b1, 4'd0},  // R2
        '{1'b0, 1'b0, 2'd0, 8'd100, 3'd3, 5'd5,  1'b1, 4'd3},  // R4
        '{1'b1, 1'b0, 2'd0, 8'd100, 3'd5, 5'd5,  1'b1, 4'd5},  // R4 R5
        '{1'b0, 1'b0, 2'd0, 8'd90,  3'd6, 5'd5,  1'b0, 4'd6},  // R5
        '{1'b0, 1'b0, 2'd0, 8'd170, 3'd6, 5'd20, 1'b1, 4'd6},  // R5
        '{1'b1, 1'b1, 2'd1, 8'd60,  3'd0, 5'd1,  1'b1, 4'd0},  // R7
        '{1'b0, 1'b1, 2'd0, 8'd100, 3'd0, 5'd1,  1'b1, 4'd0},  // R7
        '{1'b1, 1'b0, 2'd2, 8'd100, 3'd0, 5'd1,  1'b0, 4'd0}   // R2
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic next_bit(input logic p, output logic b);
        b = p ? (gen[19] ^ gen[16]) : (gen[14] ^ gen[13]);
        gen = {gen[18:0], b};
    endtask

    // Drive one valid bit from this falling edge to the next
    task automatic push(input logic b);
        bit_in = b;
        bit_vld = 1'b1;
        @(negedge clk);
        bit_vld = 1'b0;
    endtask

    task automatic pulse_reseed();
        reseed = 1'b1;
        @(negedge clk);
        reseed = 1'b0;
    endtask

    task automatic host_read();
        cnt_rd = 1'b1;
        @(negedge clk);
        cnt_rd = 1'b0;
    endtask

    // Stream n bits; errors at 60, 60+gap, ... (nerr of them)
    task automatic run_stream(input logic p, input logic inv, input int kind,
                              input int n, input int nerr, input int gap);
        for (int i = 0; i < n; i++) begin
            logic b;
            logic flip;
            next_bit((kind == 2) ? ~p : p, b);
            flip = (i >= 60) && (((i - 60) % gap) == 0) && (((i - 60) / gap) < nerr);
            push((kind == 1) ? 1'b1 : (b ^ inv ^ flip));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got %0d expected %0d", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 sync", 32'(sync_o), 32'd0);
        check("R1 count", 32'(err_cnt), 32'd0);
        check("R1 narrow count", 32'(err_cnt_n), 32'd0);

        det_en = 1'b1;
        for (int v = 0; v < NV; v++) begin
            poly_sel = VECS[v].poly;
            invert   = VECS[v].inv;
            pulse_reseed();
            host_read();
            gen = SEED;
            run_stream(VECS[v].poly, VECS[v].inv, int'(VECS[v].kind),
                       int'(VECS[v].nbits), int'(VECS[v].nerr), int'(VECS[v].gap));
            check($sformatf("R2/R4/R5/R7 vec%0d sync", v), 32'(sync_o), 32'(VECS[v].xsync));
            check($sformatf("R2/R4/R5/R7 vec%0d count", v), 32'(err_cnt), 32'(VECS[v].xcnt));
        end

        // R3: exact 32-bit run (inverted all ones gives zeros matching cleared history)
        poly_sel = 1'b1; invert = 1'b1;
        pulse_reseed();
        host_read();
        for (int i = 0; i < 31; i++) push(1'b1);
        check("R3 no sync at 31", 32'(sync_o), 32'd0);
        push(1'b1);
        check("R3 sync at 32", 32'(sync_o), 32'd1);

        // R8: reseed while enabled drops sync next edge
        pulse_reseed();
        check("R8 reseed drop", 32'(sync_o), 32'd0);
        check("R8 command self-clears", 32'(reseed), 32'd0);

        // R6: loss then automatic re-hunt
        poly_sel = 1'b0; invert = 1'b0;
        pulse_reseed();
        host_read();
        gen = SEED;
        run_stream(1'b0, 1'b0, 0, 81, 6, 2);
        check("R6 lost", 32'(sync_o), 32'd0);
        check("R6 count at loss", 32'(err_cnt), 32'd6);
        run_stream(1'b0, 1'b0, 0, 100, 0, 1);
        check("R6 resync", 32'(sync_o), 32'd1);
        check("R6 hunt not counted", 32'(err_cnt), 32'd6);

        // R9: disabled detector ignores bits and reseed, keeps count
        det_en = 1'b0;
        #1;
        check("R9 sync off", 32'(sync_o), 32'd0);
        @(negedge clk);
        pulse_reseed();
        for (int i = 0; i < 10; i++) push(i[0]);
        check("R9 count frozen", 32'(err_cnt), 32'd6);
        det_en = 1'b1;
        run_stream(1'b0, 1'b0, 0, 20, 0, 1);
        check("R9 state kept, reseed ignored", 32'(sync_o), 32'd1);
        check("R9 count after re-enable", 32'(err_cnt), 32'd6);

        // R10: read clear and read colliding with an error
        host_read();
        check("R10 cleared", 32'(err_cnt), 32'd0);
        for (int i = 0; i < 2; i++) begin
            logic b;
            next_bit(1'b0, b);
            push(~b);
        end
        check("R10 two errors", 32'(err_cnt), 32'd2);
        begin
            logic b;
            next_bit(1'b0, b);
            cnt_rd = 1'b1;
            push(~b);
            cnt_rd = 1'b0;
        end
        check("R10 read with error", 32'(err_cnt), 32'd1);
        begin
            logic b;
            next_bit(1'b0, b);
            push(b);
        end
        check("R10 holds", 32'(err_cnt), 32'd1);

        // R11: saturation on the narrow counter
        host_read();
        for (int pass = 0; pass < 4; pass++) begin
            pulse_reseed();
            gen = SEED;
            run_stream(1'b0, 1'b0, 0, 100, 5, 5);
        end
        check("R11 wide count", 32'(err_cnt), 32'd20);
        check("R11 narrow saturates", 32'(err_cnt_n), 32'd15);
        check("R11 still synced", 32'(sync_o), 32'd1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule